// File: doc/BRIEF.md
# Parameterised Duty-Cycle Clock Divider

The block produces a slow clock from a fast one. A binary counter steps through `DIV_RATIO` states and wraps back to zero, so each output period spans exactly `DIV_RATIO` input periods. The output is held low for the first `DIV_RATIO - HIGH_CYCLES` of those periods and high for the last `HIGH_CYCLES`. Each output period therefore starts low and has exactly one rising edge. The output comes straight from a flop, so it carries no decode glitches.

Parameters fix the behaviour at elaboration:
- which edge of `clk` the block counts on;
- whether the enable input is honoured at all, and if so its active level;
- one of four reset styles: synchronous or asynchronous, each active high or active low.

The internal state can only be loaded by reset, so the block must be reset before its output is used. Reset always places the divider at the start of a low phase. Parameter values outside the legal range stop elaboration.

Top module: `tick_divider`

## Requirements
- R1: With counting enabled, `clk_out` repeats every `DIV_RATIO` counting edges and rises exactly once in each such span; the internal count stays within 0 to `DIV_RATIO - 1`.
- R2: After k counting edges since reset release, `clk_out` is 1 when (k mod `DIV_RATIO`) is at least `DIV_RATIO - HIGH_CYCLES`, otherwise 0. It is therefore low for `DIV_RATIO - HIGH_CYCLES` edges and then high for `HIGH_CYCLES` edges.
- R3: While reset is active `clk_out` is 0. After reset is released, the first rising edge of `clk_out` follows the (`DIV_RATIO - HIGH_CYCLES`)-th counting edge, even when reset was applied in the middle of a high phase.
- R4: With `COUNT_EDGE` set to falling (enum value 1), the state advances only on falling edges of `clk`, and `clk_out` changes only after a falling edge.
- R5: With `USE_ENABLE` = 1, counting is gated by `clk_en`. The active level is 1 when `EN_ACTIVE_LOW` = 0 and 0 when `EN_ACTIVE_LOW` = 1. While the enable is inactive, the count and `clk_out` hold their values, and counting resumes from the held point.
- R6: With `USE_ENABLE` = 0, `clk_en` has no effect, and the block counts on every counting edge.
- R7: In the synchronous reset modes (`RST_STYLE` 0 = high, 2 = low), an asserted reset takes effect only at the next counting edge; until then `clk_out` keeps its value.
- R8: In the asynchronous reset modes (`RST_STYLE` 1 = high, 3 = low), asserting reset drives `clk_out` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock; its rising or falling edge is counted |
| clk_en | input | 1 | Counting enable; polarity set by parameter, ignored when `USE_ENABLE` = 0 |
| rst | input | 1 | Reset; its level and timing are set by `RST_STYLE` |
| clk_out | output | 1 | Divided clock, registered |

## Verification
Several properties are checked on every counting edge:
- the count never leaves its range and wraps to zero after the last state;
- the output always agrees with the count's phase;
- the output rises only at the threshold count;
- neither the count nor the output moves while the enable is inactive.

Some behaviours only show across time or between instances, so directed scenarios are needed to show them:
- the reset style, synchronous against asynchronous, since the properties are disabled during reset;
- the choice of counting edge;
- the output period and high time seen at the pin;
- the full low phase after a reset applied mid-period.

Those scenarios compare four differently configured instances against a bench-side edge count.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } tdiv_edge_e;

  typedef enum logic [1:0] {
    RST_SYNC_HI  = 2'd0,
    RST_ASYNC_HI = 2'd1,
    RST_SYNC_LO  = 2'd2,
    RST_ASYNC_LO = 2'd3
  } tdiv_rst_e;

  // Counter width able to hold 0 .. ratio-1
  function automatic int tdiv_cnt_width(input int ratio);
    return (ratio < 2) ? 1 : $clog2(ratio);
  endfunction

  // First count value at which the output is high
  function automatic int tdiv_rise_point(input int ratio, input int high);
    return ratio - high;
  endfunction

  function automatic bit tdiv_is_async(input tdiv_rst_e style);
    return (style == RST_ASYNC_HI) || (style == RST_ASYNC_LO);
  endfunction

  function automatic bit tdiv_is_low(input tdiv_rst_e style);
    return (style == RST_SYNC_LO) || (style == RST_ASYNC_LO);
  endfunction

  function automatic bit tdiv_params_ok(input int ratio, input int high);
    return (ratio >= 2) && (high >= 1) && (high <= ratio - 1);
  endfunction

endpackage

// File: rtl/tdiv_gate.sv
// Normalises the clock edge, reset level and enable level into
// positive-sense internal signals.
module tdiv_gate
  import tdiv_pkg::*;
#(
  parameter tdiv_edge_e COUNT_EDGE    = EDGE_RISE,
  parameter tdiv_rst_e  RST_STYLE     = RST_SYNC_HI,
  parameter bit         USE_ENABLE    = 1'b1,
  parameter bit         EN_ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic clk_en,
  input  logic rst,
  output logic tick_clk,
  output logic rst_hit,
  output logic step
);

  localparam bit RST_LOW = tdiv_is_low(RST_STYLE);

  logic en_true;

  generate
    if (COUNT_EDGE == EDGE_FALL) begin : g_fall
      assign tick_clk = ~clk;
    end else begin : g_rise
      assign tick_clk = clk;
    end
  endgenerate

  assign rst_hit = RST_LOW ? ~rst : rst;
  assign en_true = EN_ACTIVE_LOW ? ~clk_en : clk_en;
  assign step    = USE_ENABLE ? en_true : 1'b1;

endmodule

// File: rtl/tdiv_count.sv
// Wrapping binary phase counter.
module tdiv_count
  import tdiv_pkg::*;
#(
  parameter int        DIV_RATIO = 4,
  parameter tdiv_rst_e RST_STYLE = RST_SYNC_HI,
  localparam int       CNT_W     = tdiv_cnt_width(DIV_RATIO)
) (
  input  logic             tick_clk,
  input  logic             rst_hit,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap_ev
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

  assign wrap_ev = step && (cnt == LAST);
  assign cnt_nxt = !step  ? cnt :
                   wrap_ev ? '0 : cnt + 1'b1;

  generate
    if (tdiv_is_async(RST_STYLE)) begin : g_async
      always_ff @(posedge tick_clk or posedge rst_hit) begin
        if (rst_hit) cnt <= '0;
        else         cnt <= cnt_nxt;
      end
    end else begin : g_sync
      always_ff @(posedge tick_clk) begin
        if (rst_hit) cnt <= '0;
        else         cnt <= cnt_nxt;
      end
    end
  endgenerate

  AST_CNT_IN_RANGE: assert property (@(posedge tick_clk) disable iff (rst_hit)
    cnt <= LAST);  // R1
  AST_WRAP_TO_ZERO: assert property (@(posedge tick_clk) disable iff (rst_hit)
    wrap_ev |=> (cnt == '0));  // R1
  AST_CNT_HOLDS: assert property (@(posedge tick_clk) disable iff (rst_hit)
    !step |=> $stable(cnt));  // R5

endmodule

// File: rtl/tdiv_shape.sv
// Registered output stage: decodes the next count so the flop output
// always matches the present count's phase.
module tdiv_shape
  import tdiv_pkg::*;
#(
  parameter int        DIV_RATIO   = 4,
  parameter int        HIGH_CYCLES = 2,
  parameter tdiv_rst_e RST_STYLE   = RST_SYNC_HI,
  localparam int       CNT_W       = tdiv_cnt_width(DIV_RATIO)
) (
  input  logic             tick_clk,
  input  logic             rst_hit,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             clk_out
);

  localparam logic [CNT_W-1:0] RISE_AT = CNT_W'(tdiv_rise_point(DIV_RATIO, HIGH_CYCLES));

  logic out_nxt;
  assign out_nxt = (cnt_nxt >= RISE_AT);

  generate
    if (tdiv_is_async(RST_STYLE)) begin : g_async
      always_ff @(posedge tick_clk or posedge rst_hit) begin
        if (rst_hit) clk_out <= 1'b0;
        else         clk_out <= out_nxt;
      end
    end else begin : g_sync
      always_ff @(posedge tick_clk) begin
        if (rst_hit) clk_out <= 1'b0;
        else         clk_out <= out_nxt;
      end
    end
  endgenerate

  AST_OUT_MATCHES_PHASE: assert property (@(posedge tick_clk) disable iff (rst_hit)
    clk_out == (cnt >= RISE_AT));  // R2
  AST_RISE_AT_THRESHOLD: assert property (@(posedge tick_clk) disable iff (rst_hit)
    $rose(clk_out) |-> (cnt == RISE_AT));  // R2
  AST_OUT_HOLDS: assert property (@(posedge tick_clk) disable iff (rst_hit)
    !step |=> $stable(clk_out));  // R5

endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import tdiv_pkg::*;
#(
  parameter int         DIV_RATIO     = 4,
  parameter int         HIGH_CYCLES   = 2,
  parameter tdiv_edge_e COUNT_EDGE    = EDGE_RISE,
  parameter tdiv_rst_e  RST_STYLE     = RST_SYNC_HI,
  parameter bit         USE_ENABLE    = 1'b1,
  parameter bit         EN_ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic clk_en,
  input  logic rst,
  output logic clk_out
);

  localparam int CNT_W = tdiv_cnt_width(DIV_RATIO);

  generate
    if (!tdiv_params_ok(DIV_RATIO, HIGH_CYCLES)) begin : g_bad_params
      $error("tick_divider: need DIV_RATIO >= 2 and 1 <= HIGH_CYCLES <= DIV_RATIO-1");
    end
  endgenerate

  logic             tick_clk;
  logic             rst_hit;
  logic             step;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap_ev;

  tdiv_gate #(
    .COUNT_EDGE   (COUNT_EDGE),
    .RST_STYLE    (RST_STYLE),
    .USE_ENABLE   (USE_ENABLE),
    .EN_ACTIVE_LOW(EN_ACTIVE_LOW)
  ) u_gate (
    .clk     (clk),
    .clk_en  (clk_en),
    .rst     (rst),
    .tick_clk(tick_clk),
    .rst_hit (rst_hit),
    .step    (step)
  );

  tdiv_count #(
    .DIV_RATIO(DIV_RATIO),
    .RST_STYLE(RST_STYLE)
  ) u_count (
    .tick_clk(tick_clk),
    .rst_hit (rst_hit),
    .step    (step),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .wrap_ev (wrap_ev)
  );

  tdiv_shape #(
    .DIV_RATIO  (DIV_RATIO),
    .HIGH_CYCLES(HIGH_CYCLES),
    .RST_STYLE  (RST_STYLE)
  ) u_shape (
    .tick_clk(tick_clk),
    .rst_hit (rst_hit),
    .step    (step),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .clk_out (clk_out)
  );

  // A wrap always lands the output in its low phase
  AST_WRAP_STARTS_LOW: assert property (@(posedge tick_clk) disable iff (rst_hit)
    wrap_ev |=> !clk_out);  // R2

endmodule

// File: tb/tick_divider_test.sv
module tick_divider_test;
  import tdiv_pkg::*;

  localparam int DIV  = 5;
  localparam int HIGH = 2;
  localparam int RISE = DIV - HIGH;

  logic clk = 1'b0;
  logic rst_h, rst_l;
  logic en_hi, en_lo, en_x;
  logic [3:0] outs;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int kk [4];

  initial forever #4 clk = ~clk;  // 125 MHz

  // 0: rising, sync high reset, enable active high
  tick_divider #(.DIV_RATIO(DIV), .HIGH_CYCLES(HIGH), .COUNT_EDGE(EDGE_RISE),
    .RST_STYLE(RST_SYNC_HI), .USE_ENABLE(1'b1), .EN_ACTIVE_LOW(1'b0))
    uut (.clk(clk), .clk_en(en_hi), .rst(rst_h), .clk_out(outs[0]));
  // 1: falling, async low reset, enable active low
  tick_divider #(.DIV_RATIO(DIV), .HIGH_CYCLES(HIGH), .COUNT_EDGE(EDGE_FALL),
    .RST_STYLE(RST_ASYNC_LO), .USE_ENABLE(1'b1), .EN_ACTIVE_LOW(1'b1))
    uut_fa (.clk(clk), .clk_en(en_lo), .rst(rst_l), .clk_out(outs[1]));
  // 2: rising, async high reset, enable ignored
  tick_divider #(.DIV_RATIO(DIV), .HIGH_CYCLES(HIGH), .COUNT_EDGE(EDGE_RISE),
    .RST_STYLE(RST_ASYNC_HI), .USE_ENABLE(1'b0), .EN_ACTIVE_LOW(1'b0))
    uut_ra (.clk(clk), .clk_en(en_x), .rst(rst_h), .clk_out(outs[2]));
  // 3: falling, sync low reset, enable active high
  tick_divider #(.DIV_RATIO(DIV), .HIGH_CYCLES(HIGH), .COUNT_EDGE(EDGE_FALL),
    .RST_STYLE(RST_SYNC_LO), .USE_ENABLE(1'b1), .EN_ACTIVE_LOW(1'b0))
    uut_fs (.clk(clk), .clk_en(en_hi), .rst(rst_l), .clk_out(outs[3]));

  // Bench edge counts per instance, from the requirements
  initial begin
    kk[0] = 0; kk[1] = 0; kk[2] = 0; kk[3] = 0;
  end
  always @(posedge clk) begin
    if (rst_h) kk[0] = 0; else if (en_hi) kk[0] = (kk[0] + 1) % DIV;
    if (rst_h) kk[2] = 0; else kk[2] = (kk[2] + 1) % DIV;
  end
  always @(negedge clk) begin
    if (!rst_l) kk[1] = 0; else if (!en_lo) kk[1] = (kk[1] + 1) % DIV;
    if (!rst_l) kk[3] = 0; else if (en_hi) kk[3] = (kk[3] + 1) % DIV;
  end
  always @(posedge rst_h) kk[2] = 0;   // R8 async
  always @(negedge rst_l) kk[1] = 0;   // R8 async

  // Ignored enable toggles off the clock edges
  initial begin
    en_x = 1'b0;
    #1;
    forever #8 en_x = ~en_x;
  end

  task automatic check_bit(input string tag, input int idx, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s inst%0d actual=%b expected=%b t=%0t", tag, idx, act, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all(input string tag);
    for (int i = 0; i < 4; i++) check_bit(tag, i, outs[i], kk[i] >= RISE);
  endtask

  task automatic sweep(input int n, input string tag);
    for (int j = 0; j < n; j++) begin
      @(posedge clk); #2; cmp_all(tag);
      @(negedge clk); #2; cmp_all(tag);
    end
  endtask

  task automatic do_release();
    @(posedge clk); #1;
    rst_h = 1'b0; rst_l = 1'b1;
  endtask

  task automatic t_reset_state();
    repeat (3) @(posedge clk);
    #2;
    for (int i = 0; i < 4; i++) check_bit("R3 reset low", i, outs[i], 1'b0);
  endtask

  task automatic t_free_run();
    int rises = 0;
    int highs = 0;
    logic prev;
    do_release();
    sweep(12, "R2 R4 phase");
    @(posedge clk); #2;
    prev = outs[0];
    for (int j = 0; j < 10; j++) begin
      @(posedge clk); #2;
      if (outs[0] && !prev) rises++;
      if (outs[0]) highs++;
      prev = outs[0];
    end
    check_int("R1 rises in two periods", rises, 2);
    check_int("R2 high edges in two periods", highs, 2 * HIGH);
  endtask

  task automatic t_enable();
    @(negedge clk); #1;
    en_hi = 1'b0; en_lo = 1'b1;
    sweep(4, "R5 R6 enable off");
    @(negedge clk); #1;
    en_hi = 1'b1; en_lo = 1'b0;
    sweep(3, "R5 resume");
  endtask

  task automatic t_mid_reset();
    int first_high = -1;
    @(posedge clk); #1;
    rst_h = 1'b1; rst_l = 1'b0;
    repeat (2) @(posedge clk);
    do_release();
    repeat (4) @(negedge clk);
    #1;
    rst_h = 1'b1; rst_l = 1'b0;
    #1;
    check_bit("R8 async immediate", 1, outs[1], 1'b0);
    check_bit("R8 async immediate", 2, outs[2], 1'b0);
    check_bit("R7 sync waits", 0, outs[0], 1'b1);
    check_bit("R7 sync waits", 3, outs[3], 1'b1);
    sweep(3, "R7 R8 held reset");
    do_release();
    for (int j = 1; j <= DIV; j++) begin
      @(posedge clk); #2;
      if (first_high < 0 && outs[0]) first_high = j;
    end
    check_int("R3 full low phase after reset", first_high, RISE);
    sweep(6, "R3 after restart");
  endtask

  initial begin
    #(64'd1600000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_h = 1'b1; rst_l = 1'b0;
    en_hi = 1'b1; en_lo = 1'b0;
    t_reset_state();
    t_free_run();
    t_enable();
    t_mid_reset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule